// File: doc/BRIEF.md
# Snooping Coprocessor Bus Interface

This block lets a coprocessor share a memory bus with a host CPU. In coprocessor mode the CPU hands an opcode to the block over a side channel. The block then captures its operands from the data of read cycles that the CPU starts and then throws away. When execution ends, the block raises a completion pulse on its own and presents condition codes and exception flags. If the instruction stores a result, the block sources the data during a write cycle that the CPU starts.

In peripheral mode the same block is reached through a small memory-mapped register window, so any host can drive it. The host writes the operand slots and the opcode, polls a status word, and reads back the result. In this mode an instruction may take three operands instead of two.

The execution unit is a deterministic integer stub with a fixed latency. It stands in for real arithmetic so that the operand, completion and result handshakes can be checked exactly.

Top module: `cpbus_snoop`

## Requirements
- R1: After reset the output enable, completion pulse, condition codes and exception flags are low, and the status and result registers read as zero.
- R2: Opcode bits [1:0] give the operand count, bits [3:2] the function and bit 4 the store request. A coprocessor handoff (`cp_op_valid` high with `mode_periph` low) is accepted only while idle. In that mode a count above 2 is treated as 2.
- R3: In coprocessor mode the operands are taken, in order, from the `bus_rdata` values of successive `bus_rd` cycles. Read cycles after the required count has arrived do not change the operands.
- R4: Execution starts only once every operand slot that the instruction needs holds data written since the last start. In peripheral mode an opcode written before its operands waits, and reports busy, until they arrive.
- R5: The stub functions are 0 = sum, 1 = bitwise XOR, 2 = first operand minus the others, and 3 = bitwise inverse of the first operand. Any operand slot beyond the count reads as zero.
- R6: `cp_done` is a single-cycle pulse when execution ends. Condition codes are {negative bit1, zero bit0}. Exception flags are {no-operand bit1, out-of-range bit0}, where out-of-range is a carry out of the sum or a negative difference. Codes, flags and result hold until the next completion.
- R7: After a coprocessor instruction with the store bit set completes, `cp_wdata_oe` is high, and `cp_wdata` carries the result, only in the next cycle in which `bus_wr` is high. That cycle returns the block to idle. At all other times `cp_wdata_oe` and `cp_wdata` are zero.
- R8: The peripheral map is: address 0 is the opcode (a write requests execution), 1 to 3 are the operand slots, 4 is the result, and 5 is status {error bit5, busy bit4, exceptions bits3:2, codes bits1:0}.
- R9: In peripheral mode an instruction may use three operands.
- R10: A result read while busy returns the previous result and sets the sticky error bit. Any write to the status address clears it.
- R11: Register accesses made while in coprocessor mode read zero and change nothing. Coprocessor handoffs made in peripheral mode, or while not idle, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_periph | input | 1 | 1 = memory-mapped peripheral mode, 0 = coprocessor mode |
| cp_op_valid | input | 1 | CPU hands over an opcode this cycle |
| cp_opcode | input | OPC_W | Opcode from the CPU |
| bus_rd | input | 1 | CPU read cycle with valid data on the bus |
| bus_rdata | input | DATA_W | Bus data seen during CPU reads |
| bus_wr | input | 1 | CPU write cycle in progress |
| cp_wdata | output | DATA_W | Result data for the bus |
| cp_wdata_oe | output | 1 | Bus driver enable for cp_wdata |
| cp_done | output | 1 | Completion pulse |
| cp_cc | output | 2 | Condition codes {negative, zero} |
| cp_exc | output | 2 | Exception flags {no-operand, out-of-range} |
| pm_sel | input | 1 | Register window access strobe |
| pm_we | input | 1 | 1 = write, 0 = read |
| pm_addr | input | ADDR_W | Register address |
| pm_wdata | input | DATA_W | Register write data |
| pm_rdata | output | DATA_W | Register read data (combinational) |

## Verification
A miscounted operand capture shows up as a wrong stored word or wrong condition codes at the very next completion. The bench checks that completion within a few cycles of the last read. A stuck operand-valid slot shows up as an early start, which a peripheral status read exposes in the same cycle as busy clearing too soon. A broken state machine shows up at the ports as the bus driver enabled outside a store cycle, or as completion never arriving. The bench samples the driver enable on every cycle of each wait.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;
   timeunit 1ns; timeprecision 1ps;

   typedef enum logic [2:0] {
      S_IDLE,
      S_GRAB,
      S_PWAIT,
      S_RUN,
      S_STORE
   } cp_state_e;

   typedef enum logic [1:0] {
      FN_ADD = 2'd0,
      FN_XOR = 2'd1,
      FN_SUB = 2'd2,
      FN_INV = 2'd3
   } cp_fn_e;

   localparam int ST_CC_LSB  = 0;
   localparam int ST_EXC_LSB = 2;
   localparam int ST_BUSY    = 4;
   localparam int ST_ERR     = 5;
endpackage

// File: rtl/cpbus_opdec.sv
module cpbus_opdec
   import cpbus_pkg::*;
#(
   parameter int OPC_W  = 8,
   parameter int CNT_W  = 2,
   parameter int CP_MAX = 2,
   parameter int PM_MAX = 3
) (
   input  logic [OPC_W-1:0] opcode_i,
   input  logic             periph_i,
   output logic [CNT_W-1:0] need_o,
   output cp_fn_e           fn_o,
   output logic             store_o
);
   timeunit 1ns; timeprecision 1ps;

   logic [CNT_W-1:0] raw_cnt;
   logic [CNT_W-1:0] lim_cnt;

   assign raw_cnt = opcode_i[CNT_W-1:0];
   assign lim_cnt = periph_i ? CNT_W'(PM_MAX) : CNT_W'(CP_MAX);
   assign need_o  = (raw_cnt > lim_cnt) ? lim_cnt : raw_cnt;
   assign fn_o    = cp_fn_e'(opcode_i[CNT_W+1:CNT_W]);
   assign store_o = opcode_i[CNT_W+2] & ~periph_i;

   generate
      if (OPC_W > CNT_W + 3) begin : g_spare
         logic unused_spare;
         assign unused_spare = ^opcode_i[OPC_W-1:CNT_W+3];
      end
   endgenerate
endmodule

// File: rtl/cpbus_opstore.sv
module cpbus_opstore #(
   parameter int DATA_W = 32,
   parameter int N      = 3,
   localparam int IDX_W = $clog2(N),
   localparam int CNT_W = $clog2(N + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_i,
   input  logic                      wr_i,
   input  logic [IDX_W-1:0]          idx_i,
   input  logic [DATA_W-1:0]         data_i,
   output logic [N-1:0][DATA_W-1:0]  ops_o,
   output logic [N-1:0]              valid_o,
   output logic [CNT_W-1:0]          count_o
);
   timeunit 1ns; timeprecision 1ps;

   generate
      for (genvar g = 0; g < N; g++) begin : g_slot
         logic [DATA_W-1:0] data_q;
         logic              vld_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q <= '0;
               vld_q  <= 1'b0;
            end else if (clr_i) begin
               vld_q  <= 1'b0;
            end else if (wr_i && idx_i == IDX_W'(g)) begin
               data_q <= data_i;
               vld_q  <= 1'b1;
            end
         end
         assign ops_o[g]   = data_q;
         assign valid_o[g] = vld_q;
      end
   endgenerate

   assign count_o = CNT_W'($countones(valid_o));

   a_r3_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (valid_o == '0))
      else $error("a_r3_clr_empties");
endmodule

// File: rtl/cpbus_exec.sv
module cpbus_exec
   import cpbus_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int N      = 3,
   parameter int CNT_W  = 2,
   parameter int LAT    = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  cp_fn_e                    fn_i,
   input  logic [CNT_W-1:0]          need_i,
   input  logic [N-1:0][DATA_W-1:0]  ops_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic [DATA_W-1:0]         result_o,
   output logic [1:0]                cc_o,
   output logic [1:0]                exc_o
);
   timeunit 1ns; timeprecision 1ps;

   localparam int XW = DATA_W + $clog2(N) + 1;

   logic [N-1:0][DATA_W-1:0] used;
   logic [XW-1:0]            acc;
   logic [DATA_W-1:0]        xr;
   logic [DATA_W-1:0]        val;
   logic                     rng;
   logic                     finish;

   generate
      for (genvar g = 0; g < N; g++) begin : g_mask
         assign used[g] = (CNT_W'(g) < need_i) ? ops_i[g] : '0;
      end
   endgenerate

   always_comb begin
      acc = '0;
      xr  = '0;
      if (fn_i == FN_SUB) begin
         acc = XW'(used[0]);
         for (int i = 1; i < N; i++) acc = acc - XW'(used[i]);
      end else begin
         for (int i = 0; i < N; i++) acc = acc + XW'(used[i]);
      end
      for (int i = 0; i < N; i++) xr = xr ^ used[i];
      case (fn_i)
         FN_ADD, FN_SUB: val = acc[DATA_W-1:0];
         FN_XOR:         val = xr;
         default:        val = ~used[0];
      endcase
      rng = (fn_i == FN_ADD || fn_i == FN_SUB) && (|acc[XW-1:DATA_W]);
   end

   generate
      if (LAT == 1) begin : g_lat_one
         assign finish = busy_o;
      end else begin : g_lat_cnt
         localparam int CW = $clog2(LAT);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (start_i) cnt_q <= '0;
            else if (busy_o)  cnt_q <= cnt_q + 1'b1;
         end
         assign finish = busy_o && (cnt_q == CW'(LAT - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o   <= 1'b0;
         done_o   <= 1'b0;
         result_o <= '0;
         cc_o     <= '0;
         exc_o    <= '0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            busy_o <= 1'b1;
         end else if (finish) begin
            busy_o   <= 1'b0;
            done_o   <= 1'b1;
            result_o <= val;
            cc_o     <= {val[DATA_W-1], val == '0};
            exc_o    <= {need_i == '0, rng};
         end
      end
   end

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o)
      else $error("a_r6_done_single");

   a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o))
      else $error("a_r6_result_hold");
endmodule

// File: rtl/cpbus_snoop.sv
module cpbus_snoop
   import cpbus_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int OPC_W  = 8,
   parameter int ADDR_W = 3,
   parameter int CP_MAX = 2,
   parameter int PM_MAX = 3,
   parameter int LAT    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_periph,
   input  logic              cp_op_valid,
   input  logic [OPC_W-1:0]  cp_opcode,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_wr,
   output logic [DATA_W-1:0] cp_wdata,
   output logic              cp_wdata_oe,
   output logic              cp_done,
   output logic [1:0]        cp_cc,
   output logic [1:0]        cp_exc,
   input  logic              pm_sel,
   input  logic              pm_we,
   input  logic [ADDR_W-1:0] pm_addr,
   input  logic [DATA_W-1:0] pm_wdata,
   output logic [DATA_W-1:0] pm_rdata
);
   timeunit 1ns; timeprecision 1ps;

   localparam int N       = PM_MAX;
   localparam int CNT_W   = $clog2(N + 1);
   localparam int IDX_W   = $clog2(N);
   localparam int A_OPC   = 0;
   localparam int A_RES   = N + 1;
   localparam int A_STAT  = N + 2;

   generate
      if (DATA_W <= OPC_W)            begin : g_bad_w   $error("DATA_W must exceed OPC_W"); end
      if (OPC_W < CNT_W + 3)          begin : g_bad_opc $error("OPC_W too small for fields"); end
      if (N < 2 || CP_MAX > PM_MAX)   begin : g_bad_ops $error("operand limits inconsistent"); end
      if ((1 << ADDR_W) < N + 3)      begin : g_bad_a   $error("ADDR_W too small for map"); end
      if (LAT < 1)                    begin : g_bad_lat $error("LAT must be at least 1"); end
   endgenerate

   cp_state_e                state_q;
   logic [OPC_W-1:0]         opc_q;
   logic                     mode_q;
   logic                     err_q;

   logic [CNT_W-1:0]         need;
   cp_fn_e                   fn;
   logic                     store;
   logic [N-1:0][DATA_W-1:0] ops;
   logic [N-1:0]             valid;
   logic [CNT_W-1:0]         have;
   logic [N-1:0]             need_mask;
   logic                     ready;
   logic                     start;
   logic                     busy;

   logic                     pm_hit, pm_wr, pm_rd;
   logic                     cp_take, pm_take;
   logic                     cp_cap, pm_opw;
   logic                     st_wr;
   logic [IDX_W-1:0]         wr_idx;
   logic [DATA_W-1:0]        wr_data;

   logic                     ex_busy;
   logic [DATA_W-1:0]        ex_result;
   logic                     unused_wd;

   assign unused_wd = ^pm_wdata[DATA_W-1:OPC_W];

   cpbus_opdec #(
      .OPC_W (OPC_W), .CNT_W (CNT_W), .CP_MAX (CP_MAX), .PM_MAX (PM_MAX)
   ) u_dec (
      .opcode_i (opc_q), .periph_i (mode_q),
      .need_o (need), .fn_o (fn), .store_o (store)
   );

   // Register window and handoff qualification
   assign pm_hit  = pm_sel & mode_periph;
   assign pm_wr   = pm_hit & pm_we;
   assign pm_rd   = pm_hit & ~pm_we;
   assign busy    = (state_q == S_GRAB) || (state_q == S_PWAIT) || (state_q == S_RUN);
   assign cp_take = ~mode_periph & cp_op_valid & (state_q == S_IDLE);
   assign pm_take = pm_wr & (pm_addr == ADDR_W'(A_OPC)) & (state_q == S_IDLE);
   assign st_wr   = pm_wr & (pm_addr == ADDR_W'(A_STAT));
   assign pm_opw  = pm_wr & (pm_addr >= ADDR_W'(1)) & (pm_addr <= ADDR_W'(N))
                    & ((state_q == S_IDLE) || (state_q == S_PWAIT));

   always_comb begin
      for (int i = 0; i < N; i++) need_mask[i] = (CNT_W'(i) < need);
   end
   assign ready  = ((valid | ~need_mask) == '1);
   assign start  = ((state_q == S_GRAB) || (state_q == S_PWAIT)) && ready;
   assign cp_cap = (state_q == S_GRAB) & bus_rd & ~ready;

   assign wr_idx  = cp_cap ? IDX_W'(have) : IDX_W'(pm_addr - ADDR_W'(1));
   assign wr_data = cp_cap ? bus_rdata : pm_wdata;

   cpbus_opstore #(.DATA_W (DATA_W), .N (N)) u_ops (
      .clk (clk), .rst_n (rst_n),
      .clr_i (cp_take | start),
      .wr_i (cp_cap | pm_opw),
      .idx_i (wr_idx), .data_i (wr_data),
      .ops_o (ops), .valid_o (valid), .count_o (have)
   );

   cpbus_exec #(.DATA_W (DATA_W), .N (N), .CNT_W (CNT_W), .LAT (LAT)) u_exec (
      .clk (clk), .rst_n (rst_n),
      .start_i (start), .fn_i (fn), .need_i (need), .ops_i (ops),
      .busy_o (ex_busy), .done_o (cp_done), .result_o (ex_result),
      .cc_o (cp_cc), .exc_o (cp_exc)
   );

   // Sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         opc_q   <= '0;
         mode_q  <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (cp_take) begin
                  opc_q   <= cp_opcode;
                  mode_q  <= 1'b0;
                  state_q <= S_GRAB;
               end else if (pm_take) begin
                  opc_q   <= pm_wdata[OPC_W-1:0];
                  mode_q  <= 1'b1;
                  state_q <= S_PWAIT;
               end
            end
            S_GRAB, S_PWAIT: if (ready) state_q <= S_RUN;
            S_RUN: if (cp_done) state_q <= store ? S_STORE : S_IDLE;
            S_STORE: if (bus_wr) state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                           err_q <= 1'b0;
      else if (st_wr)                                       err_q <= 1'b0;
      else if (pm_rd && pm_addr == ADDR_W'(A_RES) && busy)  err_q <= 1'b1;
   end

   // Bus result driver
   assign cp_wdata_oe = (state_q == S_STORE) & bus_wr;
   assign cp_wdata    = cp_wdata_oe ? ex_result : '0;

   // Register readback
   always_comb begin
      pm_rdata = '0;
      if (pm_hit) begin
         if (pm_addr == ADDR_W'(A_OPC)) pm_rdata = DATA_W'(opc_q);
         if (pm_addr == ADDR_W'(A_RES)) pm_rdata = ex_result;
         if (pm_addr == ADDR_W'(A_STAT)) begin
            pm_rdata[ST_ERR]                  = err_q;
            pm_rdata[ST_BUSY]                 = busy;
            pm_rdata[ST_EXC_LSB+1:ST_EXC_LSB] = cp_exc;
            pm_rdata[ST_CC_LSB+1:ST_CC_LSB]   = cp_cc;
         end
         for (int i = 0; i < N; i++)
            if (pm_addr == ADDR_W'(i + 1)) pm_rdata = ops[i];
      end
   end

   a_r7_oe_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cp_wdata_oe |=> (state_q == S_IDLE))
      else $error("a_r7_oe_then_idle");

   a_r3_grab_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_GRAB) |-> ($countones(valid) <= CP_MAX))
      else $error("a_r3_grab_limit");

   a_r4_start_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ex_busy) |-> ($past(state_q) == S_GRAB || $past(state_q) == S_PWAIT))
      else $error("a_r4_start_from_wait");

   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !st_wr) |=> err_q)
      else $error("a_r10_err_sticky");

   a_r11_busy_no_take: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != S_IDLE) |=> $stable(opc_q))
      else $error("a_r11_busy_no_take");
endmodule

// File: tb/cpbus_snoop_test.sv
module cpbus_snoop_test;
   timeunit 1ns; timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_periph = 1'b1;
   logic        cp_op_valid = 1'b0;
   logic [7:0]  cp_opcode = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] cp_wdata;
   logic        cp_wdata_oe;
   logic        cp_done;
   logic [1:0]  cp_cc;
   logic [1:0]  cp_exc;
   logic        pm_sel = 1'b0;
   logic        pm_we = 1'b0;
   logic [2:0]  pm_addr = '0;
   logic [31:0] pm_wdata = '0;
   logic [31:0] pm_rdata;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic [31:0] last_res = '0;

   cpbus_snoop uut (
      .clk (clk), .rst_n (rst_n), .mode_periph (mode_periph),
      .cp_op_valid (cp_op_valid), .cp_opcode (cp_opcode),
      .bus_rd (bus_rd), .bus_rdata (bus_rdata), .bus_wr (bus_wr),
      .cp_wdata (cp_wdata), .cp_wdata_oe (cp_wdata_oe), .cp_done (cp_done),
      .cp_cc (cp_cc), .cp_exc (cp_exc),
      .pm_sel (pm_sel), .pm_we (pm_we), .pm_addr (pm_addr),
      .pm_wdata (pm_wdata), .pm_rdata (pm_rdata)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void model(input logic [1:0] fn, input int need,
                                 input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                                 output logic [31:0] res, output logic [1:0] cc, output logic [1:0] exc);
      logic [31:0] u0, u1, u2;
      longint s;
      bit rng;
      u0 = (need > 0) ? a : 32'd0;
      u1 = (need > 1) ? b : 32'd0;
      u2 = (need > 2) ? c : 32'd0;
      rng = 0;
      s = 0;
      case (fn)
         2'd0: begin s = {32'd0, u0} + {32'd0, u1} + {32'd0, u2}; res = s[31:0]; rng = (s > longint'(64'hFFFF_FFFF)); end
         2'd1: res = u0 ^ u1 ^ u2;
         2'd2: begin s = {32'd0, u0} - {32'd0, u1} - {32'd0, u2}; res = s[31:0]; rng = (s < 0); end
         default: res = ~u0;
      endcase
      cc  = {res[31], res == 32'd0};
      exc = {need == 0, rng};
   endfunction

   function automatic logic [7:0] mkop(input logic [1:0] fn, input int cnt, input bit st);
      return {3'b000, st, fn, 2'(cnt)};
   endfunction

   // All tasks start and end at a falling edge.
   task automatic pm_write(input logic [2:0] a, input logic [31:0] d);
      pm_sel = 1; pm_we = 1; pm_addr = a; pm_wdata = d;
      @(negedge clk);
      pm_sel = 0; pm_we = 0;
   endtask

   task automatic pm_read(input logic [2:0] a, output logic [31:0] d);
      pm_sel = 1; pm_we = 0; pm_addr = a;
      #1 d = pm_rdata;
      @(negedge clk);
      pm_sel = 0;
   endtask

   task automatic pm_wait_idle(output logic [31:0] st);
      st = '0;
      for (int t = 0; t < 60; t++) begin
         pm_read(3'd5, st);
         if (!st[4]) break;
      end
      chk(!st[4], "R4 peripheral instruction finishes", st, '0);
   endtask

   task automatic pm_run(input logic [1:0] fn, input int cnt, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c, input string tag);
      logic [31:0] res, st, rd;
      logic [1:0] cc, exc;
      logic [31:0] d[3];
      d[0] = a; d[1] = b; d[2] = c;
      model(fn, cnt, a, b, c, res, cc, exc);
      for (int i = 0; i < cnt; i++) pm_write(3'(i + 1), d[i]);
      pm_write(3'd0, {24'd0, mkop(fn, cnt, 1'b0)});
      pm_wait_idle(st);
      pm_read(3'd4, rd);
      chk(rd == res, {tag, " result"}, rd, res);
      chk(st[3:0] == {exc, cc}, {tag, " R6 status flags"}, {28'd0, st[3:0]}, {28'd0, exc, cc});
      last_res = res;
   endtask

   task automatic cp_run(input logic [1:0] fn, input int cnt, input bit st,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                         input int nrd, input string tag);
      logic [31:0] res;
      logic [1:0] cc, exc;
      logic [31:0] d[3];
      bit seen, oe_bad;
      int need;
      d[0] = a; d[1] = b; d[2] = c;
      need = (cnt > 2) ? 2 : cnt;
      model(fn, need, a, b, c, res, cc, exc);
      cp_op_valid = 1; cp_opcode = mkop(fn, cnt, st);
      @(negedge clk);
      cp_op_valid = 0;
      for (int i = 0; i < nrd; i++) begin
         bus_rd = 1; bus_rdata = d[i];
         @(negedge clk);
      end
      bus_rd = 0;
      seen = 0; oe_bad = 0;
      for (int t = 0; t < 60; t++) begin
         if (cp_wdata_oe) oe_bad = 1;
         if (cp_done) begin seen = 1; break; end
         @(negedge clk);
      end
      chk(seen, {tag, " R6 completion pulse"}, 32'(seen), 32'd1);
      chk(!oe_bad, {tag, " R7 driver off while executing"}, 32'(oe_bad), 32'd0);
      chk(cp_cc == cc && cp_exc == exc, {tag, " R6 codes and flags"},
          {28'd0, cp_exc, cp_cc}, {28'd0, exc, cc});
      @(negedge clk);
      chk(!cp_done, {tag, " R6 pulse is one cycle"}, 32'(cp_done), 32'd0);
      #1 chk(!cp_wdata_oe && cp_wdata == 0, {tag, " R7 idle driver"}, cp_wdata, 32'd0);
      bus_wr = 1;
      #1;
      if (st) begin
         chk(cp_wdata_oe && cp_wdata == res, {tag, " R7 stored result"}, cp_wdata, res);
      end else begin
         chk(!cp_wdata_oe && cp_wdata == 0, {tag, " R7 no store pending"}, cp_wdata, 32'd0);
      end
      @(negedge clk);
      bus_wr = 0;
      #1 chk(!cp_wdata_oe, "R7 driver off after store", 32'(cp_wdata_oe), 32'd0);
      last_res = res;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd, st, seed_v;
      seed_v = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk(!cp_wdata_oe && !cp_done && cp_cc == 0 && cp_exc == 0, "R1 outputs after reset",
          {27'd0, cp_wdata_oe, cp_done, cp_cc[0], cp_exc}, 32'd0);
      pm_read(3'd5, rd);
      chk(rd == 0, "R1 status after reset", rd, 32'd0);
      pm_read(3'd4, rd);
      chk(rd == 0, "R1 result after reset", rd, 32'd0);

      // R9/R8 three-operand peripheral instruction
      pm_run(2'd0, 3, 32'd10, 32'd20, 32'd30, "R9 R8 three operand sum");
      pm_run(2'd2, 3, 32'd100, 32'd30, 32'd5, "R9 R5 three operand difference");

      // R4 opcode before operands
      pm_write(3'd0, {24'd0, mkop(2'd1, 2, 1'b0)});
      repeat (8) @(negedge clk);
      pm_read(3'd5, rd);
      chk(rd[4], "R4 waits with no operands", rd, 32'h10);
      pm_write(3'd1, 32'hF0F0_1234);
      repeat (8) @(negedge clk);
      pm_read(3'd5, rd);
      chk(rd[4], "R4 waits with one of two operands", rd, 32'h10);
      pm_write(3'd2, 32'h0FF0_4321);
      pm_wait_idle(st);
      pm_read(3'd4, rd);
      chk(rd == (32'hF0F0_1234 ^ 32'h0FF0_4321), "R4 R5 result after late operand", rd,
          32'hF0F0_1234 ^ 32'h0FF0_4321);
      last_res = rd;

      // R10 read while busy
      pm_write(3'd1, 32'd5);
      pm_write(3'd0, {24'd0, mkop(2'd0, 1, 1'b0)});
      pm_read(3'd4, rd);
      chk(rd == last_res, "R10 busy read returns old result", rd, last_res);
      pm_wait_idle(st);
      chk(st[5], "R10 sticky error set", st, 32'h20);
      pm_read(3'd4, rd);
      chk(rd == 32'd5, "R10 R5 result after busy read", rd, 32'd5);
      last_res = rd;
      pm_read(3'd5, rd);
      chk(rd[5], "R10 error still held", rd, 32'h20);
      pm_write(3'd5, 32'd0);
      pm_read(3'd5, rd);
      chk(!rd[5], "R10 error cleared by status write", rd, 32'd0);

      // R11 handoff ignored in peripheral mode
      cp_op_valid = 1; cp_opcode = 8'h1F;
      @(negedge clk);
      cp_op_valid = 0;
      pm_read(3'd0, rd);
      chk(rd == {24'd0, mkop(2'd0, 1, 1'b0)}, "R11 handoff ignored in peripheral mode", rd,
          {24'd0, mkop(2'd0, 1, 1'b0)});
      pm_read(3'd5, rd);
      chk(!rd[4], "R11 no execution from ignored handoff", rd, 32'd0);

      // R11 register window ignored in coprocessor mode
      mode_periph = 0;
      pm_write(3'd1, 32'hDEAD_BEEF);
      pm_read(3'd1, rd);
      chk(rd == 0, "R11 reads zero in coprocessor mode", rd, 32'd0);
      mode_periph = 1;
      pm_read(3'd1, rd);
      chk(rd == 32'd5, "R11 write ignored in coprocessor mode", rd, 32'd5);
      mode_periph = 0;
      @(negedge clk);

      // Coprocessor directed cases
      cp_run(2'd0, 2, 1'b1, 32'd5, 32'd7, 32'd0, 2, "R2 R3 two operand stored sum");
      cp_run(2'd0, 1, 1'b1, 32'h1111, 32'h2222, 32'h4444, 3, "R3 extra reads ignored");
      cp_run(2'd0, 3, 1'b1, 32'd40, 32'd2, 32'd1000, 3, "R2 count capped at two");
      cp_run(2'd0, 2, 1'b1, 32'hFFFF_FFFF, 32'd1, 32'd0, 2, "R6 carry out of sum");
      cp_run(2'd2, 2, 1'b1, 32'd1, 32'd2, 32'd0, 2, "R6 R5 negative difference");
      cp_run(2'd3, 0, 1'b1, 32'd9, 32'd0, 32'd0, 1, "R5 R6 no operand inverse");
      cp_run(2'd1, 2, 1'b0, 32'hAAAA_0000, 32'hAAAA_0000, 32'd0, 2, "R7 R6 no store zero xor");

      // Randomised mix
      for (int it = 0; it < 40; it++) begin
         logic [1:0] fn;
         int cnt, nrd;
         bit st_b;
         logic [31:0] a, b, c;
         fn = 2'($urandom % 4);
         cnt = int'($urandom % 4);
         st_b = 1'($urandom % 2);
         a = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
         b = ($urandom % 8 == 0) ? 32'd0 : $urandom;
         c = $urandom;
         if ($urandom % 2 == 1) begin
            mode_periph = 1;
            @(negedge clk);
            pm_run(fn, cnt, a, b, c, "R8 R5 random peripheral");
         end else begin
            mode_periph = 0;
            @(negedge clk);
            nrd = ((cnt > 2) ? 2 : cnt) + int'($urandom % 2);
            cp_run(fn, cnt, st_b, a, b, c, nrd, "R3 R5 random coprocessor");
         end
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule